// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the low address bits for a four-beat burst on a synchronous memory port. A load strobe starts a new burst. It captures a starting offset from the low address bits and the wanted order, and it clears an internal beat index. Each later clock edge that samples the active-low advance strobe low moves the burst to its next beat. The beat address wraps within an aligned group of four.

Two orders are available, and the choice is made at run time. In the exclusive-OR order, each beat address is the starting offset XORed with the beat index. In the linear order, each beat address is the starting offset plus the beat index, modulo four. Read and write bursts use the same sequencing. The order is latched when the burst is loaded, so a change on the mode pin in the middle of a burst does not disturb the running sequence. A flag marks the final beat.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, and until the first load, `addr_o` is 0 and `last_o` is 0.
- R2: A clock edge that samples `load_i` high captures `start_off_i`, sets the beat index to 0, and makes `addr_o` equal `start_off_i` after that edge.
- R3: When the burst was loaded with `mode_i` = 1, `addr_o` equals the starting offset XOR the beat index (start 01 gives 01, 00, 11, 10).
- R4: When the burst was loaded with `mode_i` = 0, `addr_o` equals (starting offset + beat index) mod 4 (start 11 gives 11, 00, 01, 10).
- R5: An edge that samples `adv_n_i` low during an active burst adds one to the beat index. An edge that samples `adv_n_i` high leaves `addr_o` and `last_o` unchanged.
- R6: Before the first load after reset, `adv_n_i` low has no effect, and `addr_o` stays 0.
- R7: When `load_i` is high and `adv_n_i` is low on the same edge, the load wins: the beat index becomes 0, not 1.
- R8: `last_o` is high exactly while a burst is active and the beat index is 3.
- R9: An advance from beat index 3 wraps to beat index 0, so `addr_o` returns to the starting offset.
- R10: `mode_i` is sampled only at load. Changing it during a burst does not alter the order in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Start a new burst from `start_off_i` |
| start_off_i | input | ADDR_W | Starting offset (low address bits) |
| adv_n_i | input | 1 | Active-low advance strobe |
| mode_i | input | 1 | Order select: 1 selects the exclusive-OR order, 0 selects the linear order |
| addr_o | output | ADDR_W | Current burst beat address |
| last_o | output | 1 | High while on the final beat |

## Verification
The bench builds the block with the default `ADDR_W` = 2, which gives four-beat bursts. At this size every starting offset can be loaded in both orders. Each such burst is then stepped through a full wrap and one beat beyond, so every table entry of both orders is reached. The small width also puts the corner cases within a few cycles: advance before any load, load colliding with advance, idle cycles inside a burst, and a mode flip in the middle of a burst.

// File: rtl/bseq_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: nothing beyond a single-bit order select.
package bseq_pkg;

    // Burst order as latched at load time.
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

endpackage

// File: rtl/bseq_track.sv
// Module: bseq_track
// Holds the burst state: the latched starting offset, the latched order,
// the beat index and a flag that marks an active burst.
// Assumes: load has priority over advance; advance is ignored until the
// first load after reset; the index wraps naturally at 2**ADDR_W.
module bseq_track
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_off_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] off_o,
    output logic [ADDR_W-1:0] idx_o,
    output order_e            order_o,
    output logic              live_o
);

    localparam logic [ADDR_W-1:0] IDX_STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] off_q;
    logic [ADDR_W-1:0] idx_q;
    order_e            order_q;
    logic              live_q;

    // Capture the offset and order on load, and step the index on a qualified advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q   <= '0;
            idx_q   <= '0;
            order_q <= ORD_LINEAR;
            live_q  <= 1'b0;
        end else if (load_i) begin
            off_q   <= start_off_i;
            idx_q   <= '0;
            order_q <= order_e'(mode_i);
            live_q  <= 1'b1;
        end else if (live_q && !adv_n_i) begin
            idx_q   <= idx_q + IDX_STEP;
        end
    end

    assign off_o   = off_q;
    assign idx_o   = idx_q;
    assign order_o = order_q;
    assign live_o  = live_q;

endmodule

// File: rtl/bseq_map.sv
// Module: bseq_map
// Combinational map from (offset, beat index, order) to the beat address.
// Assumes: the linear sum is truncated to ADDR_W bits (modulo wrap).
module bseq_map
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] off_i,
    input  logic [ADDR_W-1:0] idx_i,
    input  order_e            order_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] xor_addr;
    logic [ADDR_W-1:0] lin_addr;

    // Exclusive-OR order, built one bit at a time.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_xor_bit
        assign xor_addr[b] = off_i[b] ^ idx_i[b];
    end

    // Linear order: modulo add.
    assign lin_addr = off_i + idx_i;

    // Pick the order that was latched at load.
    always_comb begin
        addr_o = (order_i == ORD_XOR) ? xor_addr : lin_addr;
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Burst address sequencer with run-time choice of exclusive-OR or linear
// wrap order. The outputs depend only on registers, so they are stable
// through the whole cycle.
// Assumes: the caller keeps the upper address bits; one burst spans
// 2**ADDR_W beats.
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_off_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    localparam int                BEATS    = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(BEATS - 1);

    logic [ADDR_W-1:0] off_w;
    logic [ADDR_W-1:0] idx_w;
    order_e            order_w;
    logic              live_w;

    bseq_track #(.ADDR_W(ADDR_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .start_off_i (start_off_i),
        .adv_n_i     (adv_n_i),
        .mode_i      (mode_i),
        .off_o       (off_w),
        .idx_o       (idx_w),
        .order_o     (order_w),
        .live_o      (live_w)
    );

    bseq_map #(.ADDR_W(ADDR_W)) u_map (
        .off_i   (off_w),
        .idx_i   (idx_w),
        .order_i (order_w),
        .addr_o  (addr_o)
    );

    // Flag the final beat of an active burst.
    always_comb begin
        last_o = live_w && (idx_w == LAST_IDX);
    end

endmodule

// File: rtl/bseq_checker.sv
// Module: bseq_checker
// Temporal checks on the sequencer ports, bound to burst_addr_seq.
// Assumes: the same synchronous active-low reset as the design.
module bseq_checker #(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [ADDR_W-1:0] start_off_i,
    input logic              adv_n_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              last_o
);

    logic seen_load;

    // Remember whether any burst has started since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      seen_load <= 1'b0;
        else if (load_i) seen_load <= 1'b1;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_load |-> (addr_o == '0 && !last_o)); // R6

    AST_LOAD_SEEDS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(start_off_i) && !last_o)); // R2

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> ($stable(addr_o) && $stable(last_o))); // R5

    AST_ADV_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_load && !load_i && !adv_n_i) |=> (addr_o != $past(addr_o))); // R5

    AST_LAST_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !load_i && !adv_n_i) |=> !last_o); // R9

endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W)) u_bseq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .start_off_i (start_off_i),
    .adv_n_i     (adv_n_i),
    .addr_o      (addr_o),
    .last_o      (last_o)
);

// File: tb/burst_addr_seq_bench.sv
// Scoreboard bench: a driver task applies one cycle of stimulus, steps a
// reference model built from the requirements and queues the expected
// outputs; a monitor pops and compares them on the following falling edge.
module burst_addr_seq_bench;

    localparam int ADDR_W = 2;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic              last;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic [ADDR_W-1:0] start_off_i = '0;
    logic              adv_n_i = 1'b1;
    logic              mode_i = 1'b0;
    logic [ADDR_W-1:0] addr_o;
    logic              last_o;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    exp_t sb_q[$];

    // Reference state
    logic [ADDR_W-1:0] m_off = '0;
    logic [ADDR_W-1:0] m_idx = '0;
    logic              m_xor = 1'b0;
    logic              m_live = 1'b0;

    burst_addr_seq #(.ADDR_W(ADDR_W)) u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_off_i(start_off_i),
        .adv_n_i(adv_n_i), .mode_i(mode_i), .addr_o(addr_o), .last_o(last_o)
    );

    always #10 clk = ~clk; // 50 MHz

    // Watchdog: count the hang as a failure and still print the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=5000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // Monitor: compare the design outputs against queued expectations.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            vectors++;
            if (addr_o !== e.addr || last_o !== e.last) begin
                errors++;
                $display("FAIL %s: actual addr=%b last=%b expected addr=%b last=%b",
                         e.tag, addr_o, last_o, e.addr, e.last);
            end
        end
    end

    // Driver: one cycle of stimulus, then the model step and the expected push.
    task automatic step(input logic ld, input logic [ADDR_W-1:0] so,
                        input logic advn, input logic md, input string tag);
        exp_t e;
        @(negedge clk);
        load_i = ld; start_off_i = so; adv_n_i = advn; mode_i = md;
        @(posedge clk);
        if (ld) begin
            m_off = so; m_idx = '0; m_xor = md; m_live = 1'b1;
        end else if (m_live && !advn) begin
            m_idx = m_idx + 1'b1;
        end
        e.addr = m_xor ? (m_off ^ m_idx) : ADDR_W'(m_off + m_idx);
        e.last = m_live && (m_idx == 2'd3);
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 2'b00, 1'b1, 1'b0, "R1 reset state");
        step(1'b0, 2'b11, 1'b0, 1'b1, "R6 advance before load");
        step(1'b0, 2'b10, 1'b0, 1'b0, "R6 advance before load");
        // Every offset in both orders, through a full wrap and one beat more.
        for (int md = 1; md >= 0; md--) begin
            for (int so = 0; so < 4; so++) begin
                step(1'b1, 2'(so), 1'b1, 1'(md), "R2 load seeds offset");
                for (int k = 0; k < 5; k++) begin
                    step(1'b0, 2'b00, 1'b0, 1'(md),
                         (k == 3) ? "R9 wrap to start" :
                         (md == 1) ? "R3 xor order R8 last" : "R4 linear order R8 last");
                end
            end
        end
        // Hold cycles inside a burst.
        step(1'b1, 2'b01, 1'b1, 1'b0, "R2 load");
        step(1'b0, 2'b00, 1'b0, 1'b0, "R5 advance");
        step(1'b0, 2'b00, 1'b1, 1'b0, "R5 hold");
        step(1'b0, 2'b00, 1'b1, 1'b0, "R5 hold");
        step(1'b0, 2'b00, 1'b0, 1'b0, "R5 advance");
        step(1'b0, 2'b00, 1'b0, 1'b0, "R8 last beat");
        step(1'b0, 2'b00, 1'b1, 1'b0, "R8 last held");
        // Load and advance together.
        step(1'b1, 2'b10, 1'b0, 1'b1, "R7 load beats advance");
        step(1'b1, 2'b11, 1'b0, 1'b0, "R7 load beats advance");
        // Mode flip inside a burst.
        step(1'b1, 2'b01, 1'b1, 1'b1, "R10 load xor");
        step(1'b0, 2'b00, 1'b0, 1'b0, "R10 mode change ignored");
        step(1'b0, 2'b00, 1'b0, 1'b0, "R10 mode change ignored");
        step(1'b0, 2'b00, 1'b0, 1'b1, "R10 mode change ignored");
        step(1'b1, 2'b11, 1'b1, 1'b0, "R10 load linear");
        step(1'b0, 2'b00, 1'b0, 1'b1, "R10 mode change ignored");
        step(1'b0, 2'b00, 1'b0, 1'b1, "R10 mode change ignored");
        // Reset in the middle of a burst returns to idle.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_off = '0; m_idx = '0; m_xor = 1'b0; m_live = 1'b0;
        step(1'b0, 2'b00, 1'b0, 1'b0, "R1 R6 idle after reset");
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule